// File: doc/BRIEF.md
# Dual-limit watchdog comparator

The block watches a stream of signed conversion results and tests each accepted result against a small bank of programmable limits, one limit per cycle, always in ascending limit order. Samples and limits are both in sign-magnitude form: an 8-bit magnitude with a separate sign bit. Each limit also carries a trigger-sense bit. With sense set, a sample strictly above the limit trips that limit. With sense clear, a sample strictly below it trips the limit. A tripped limit raises its own sticky interrupt flag. A one-cycle done strobe marks the end of the sequence.

Samples arrive on a valid/ready interface. The block takes a sample only when valid and ready are both high. Ready drops for the whole evaluation of an enabled sample, so a producer that holds valid simply waits and loses nothing. A sample whose compare-enable bit is clear is consumed and discarded in one cycle. Limits and flags are reached through a plain register port: writes are synchronous and reads are combinational.

Top module: `wdl_top`

## Requirements
- R1: A limit register at address 0 (limit 1) or address 1 (limit 2) keeps bits 7:0 as the magnitude, bit 8 as the sign (1 = negative) and bit 9 as the trigger sense. Bits 15:10 ignore writes and read back as zero.
- R2: Samples are 9 bits wide: bit 8 is the sign and bits 7:0 the magnitude. Samples and limits are compared as signed numbers, so negative zero equals positive zero.
- R3: With sense 1, a limit trips only when the sample is strictly greater than it. With sense 0, it trips only when the sample is strictly less. An equal sample never trips a limit.
- R4: An accepted, enabled sample is compared with limit 1 at the first clock edge after acceptance and with limit 2 at the second. Its flags (bit 0 for limit 1, bit 1 for limit 2) become visible in those same cycles.
- R5: A flag stays set until a write to address 2 with a 1 in its bit position, or until reset. A clear that meets a new trip on the same edge leaves the flag set. Writing 0 bits changes nothing. Address 2 reads the flags in bits 1:0.
- R6: The done strobe is high for exactly the one cycle after the edge that evaluates limit 2.
- R7: A sample accepted with its compare-enable bit clear sets no flag and produces no done strobe, and ready stays high.
- R8: Ready is high when idle and low from acceptance of an enabled sample until done. A sample held valid while ready is low is taken exactly once, at the first edge with ready high.
- R9: After reset, both limits and both flags read zero, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for write and read (0, 1 limits, 2 flags) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Combinational read data at cfg_addr |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Block can take a sample |
| smp_cmp_en | input | 1 | Compare-enable bit travelling with the sample |
| smp_data | input | 9 | Sign-magnitude sample |
| lim_irq | output | 2 | Sticky per-limit interrupt flags |
| cmp_done | output | 1 | One-cycle strobe after the last comparison |

## Verification
The bench goes after signed corner cases. A negative sample with a large magnitude must not trip a small positive "above" limit, which catches a design that compares magnitudes without signs. Negative zero must compare equal to positive zero, which catches one that orders the two zeros apart. Equal samples check strictness. A mid-sequence check confirms that limit 1's flag is set one cycle before limit 2's, which catches swapped or merged steps. Further tests aim a clear at a flag in the cycle it trips, hold valid across a busy period to catch double or lost acceptance, and send a disabled sample that must leave flags and done untouched.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_EVAL = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wdl_limit_bank.sv
module wdl_limit_bank #(
  parameter int unsigned NUM_LIM = 2,
  parameter int unsigned MAG_W   = 8,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned AW      = 2,
  localparam int unsigned FIELD_W = MAG_W + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  output logic [NUM_LIM-1:0][FIELD_W-1:0] lim_q
);

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    logic [FIELD_W-1:0] field_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        field_q <= '0;
      end else if (wr_en && (wr_addr == AW'(g))) begin
        field_q <= wr_data[FIELD_W-1:0];
      end
    end

    assign lim_q[g] = field_q;

    // R1: a write to this limit stores exactly the low field bits
    a_r1_field_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == AW'(g))) |=> (field_q == $past(wr_data[FIELD_W-1:0])));
  end

endmodule

// File: rtl/wdl_cmp.sv
module wdl_cmp #(
  parameter int unsigned MAG_W = 8,
  localparam int unsigned FIELD_W = MAG_W + 2,
  localparam int unsigned SIGN_POS  = MAG_W,
  localparam int unsigned SENSE_POS = MAG_W + 1
) (
  input  logic [MAG_W:0]     smp_sm,
  input  logic [FIELD_W-1:0] lim_f,
  output logic               hit
);

  function automatic logic signed [MAG_W:0] sm_to_tc(input logic neg,
                                                     input logic [MAG_W-1:0] mag);
    logic signed [MAG_W:0] m;
    m = signed'({1'b0, mag});
    return neg ? -m : m;
  endfunction

  logic signed [MAG_W:0] smp_tc;
  logic signed [MAG_W:0] lim_tc;

  always_comb begin
    smp_tc = sm_to_tc(smp_sm[SIGN_POS], smp_sm[MAG_W-1:0]);
    lim_tc = sm_to_tc(lim_f[SIGN_POS], lim_f[MAG_W-1:0]);
    hit    = lim_f[SENSE_POS] ? (smp_tc > lim_tc) : (smp_tc < lim_tc);
  end

endmodule

// File: rtl/wdl_seq.sv
module wdl_seq
  import wdl_pkg::*;
#(
  parameter int unsigned NUM_LIM = 2,
  parameter int unsigned MAG_W   = 8,
  localparam int unsigned SW = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic               smp_cmp_en,
  input  logic [MAG_W:0]     smp_data,
  output logic               smp_ready,
  output logic [MAG_W:0]     smp_q,
  output logic [SW-1:0]      step_q,
  output logic               eval_act,
  input  logic               hit,
  input  logic [NUM_LIM-1:0] clr_mask,
  output logic [NUM_LIM-1:0] flag_q,
  output logic               done_q
);

  localparam logic [SW-1:0] LAST = SW'(NUM_LIM - 1);

  seq_state_e state_q;
  logic       accept;

  assign smp_ready = (state_q == SQ_IDLE);
  assign accept    = smp_valid && smp_ready;
  assign eval_act  = (state_q == SQ_EVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      smp_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (accept && smp_cmp_en) begin
            smp_q   <= smp_data;
            step_q  <= '0;
            state_q <= SQ_EVAL;
          end
        end
        default: begin
          if (step_q == LAST) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LIM; i++) begin
        flag_q[i] <= (flag_q[i] && !clr_mask[i]) ||
                     (eval_act && (step_q == SW'(i)) && hit);
      end
    end
  end

  // R6: the strobe never lasts two cycles
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4, R6: the strobe follows the step that evaluates the last limit
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == SQ_EVAL) && ($past(step_q) == LAST));

  // R8: an enabled sample blocks further acceptance
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && smp_cmp_en) |=> !smp_ready);

  // R7: a disabled sample leaves the block idle with no strobe
  a_r7_skip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !smp_cmp_en) |=> (smp_ready && !done_q));

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_hold
    // R5: a flag is only lowered by a clear request
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_mask[g]) |=> flag_q[g]);
  end

endmodule

// File: rtl/wdl_top.sv
module wdl_top #(
  parameter int unsigned NUM_LIM = 2,
  parameter int unsigned MAG_W   = 8,
  parameter int unsigned REG_W   = 16,
  localparam int unsigned AW      = $clog2(NUM_LIM + 1),
  localparam int unsigned FIELD_W = MAG_W + 2,
  localparam int unsigned SW      = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic               smp_cmp_en,
  input  logic [MAG_W:0]     smp_data,
  output logic [NUM_LIM-1:0] lim_irq,
  output logic               cmp_done
);

  localparam logic [AW-1:0] FLAG_ADDR = AW'(NUM_LIM);

  logic [NUM_LIM-1:0][FIELD_W-1:0] lim_q;
  logic [FIELD_W-1:0]              lim_sel;
  logic [MAG_W:0]                  smp_q;
  logic [SW-1:0]                   step_q;
  logic                            eval_act;
  logic                            hit;
  logic [NUM_LIM-1:0]              clr_mask;

  assign clr_mask = (cfg_wr_en && (cfg_addr == FLAG_ADDR)) ? cfg_wdata[NUM_LIM-1:0] : '0;

  wdl_limit_bank #(
    .NUM_LIM(NUM_LIM), .MAG_W(MAG_W), .REG_W(REG_W), .AW(AW)
  ) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .lim_q(lim_q)
  );

  always_comb begin
    lim_sel = '0;
    for (int i = 0; i < NUM_LIM; i++) begin
      if (step_q == SW'(i)) lim_sel = lim_q[i];
    end
  end

  wdl_cmp #(.MAG_W(MAG_W)) cmp_i (
    .smp_sm(smp_q), .lim_f(lim_sel), .hit(hit)
  );

  wdl_seq #(.NUM_LIM(NUM_LIM), .MAG_W(MAG_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_cmp_en(smp_cmp_en),
    .smp_data(smp_data), .smp_ready(smp_ready), .smp_q(smp_q), .step_q(step_q),
    .eval_act(eval_act), .hit(hit), .clr_mask(clr_mask), .flag_q(lim_irq),
    .done_q(cmp_done)
  );

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_LIM; i++) begin
      if (cfg_addr == AW'(i)) cfg_rdata[FIELD_W-1:0] = lim_q[i];
    end
    if (cfg_addr == FLAG_ADDR) cfg_rdata[NUM_LIM-1:0] = lim_irq;
  end

  // R1: unused register bits always read back as zero
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:FIELD_W] == '0);

  // R5: a flag can only rise while an evaluation is under way
  a_r5_rise_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lim_irq & ~$past(lim_irq))) |-> $past(eval_act));

endmodule

// File: tb/wdl_top_tb_top.sv
module wdl_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic        smp_cmp_en = 1'b0;
  logic [8:0]  smp_data = '0;
  logic [1:0]  lim_irq;
  logic        cmp_done;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  wdl_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_cmp_en(smp_cmp_en), .smp_data(smp_data),
    .lim_irq(lim_irq), .cmp_done(cmp_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic logic [15:0] mk_lim(input logic sense, input logic neg, input logic [7:0] mag);
    return {6'b0, sense, neg, mag};
  endfunction

  task automatic set_lims(input logic [15:0] l1, input logic [15:0] l2);
    wr(2'd0, l1);
    wr(2'd1, l2);
    wr(2'd2, 16'h0003);
  endtask

  // drive one enabled sample, check flags mid-sequence and at done
  task automatic send(input string tag, input logic neg, input logic [7:0] mag,
                      input logic [1:0] prior, input logic h1, input logic h2);
    @(negedge clk);
    smp_valid = 1'b1; smp_cmp_en = 1'b1; smp_data = {neg, mag};
    @(negedge clk);
    smp_valid = 1'b0;
    chk({tag, " R8 ready low after accept"}, 32'(smp_ready), 32'd0);
    @(negedge clk);
    chk({tag, " R4 flags after limit 1"}, 32'(lim_irq), 32'({prior[1], prior[0] | h1}));
    chk({tag, " R6 no done after limit 1"}, 32'(cmp_done), 32'd0);
    @(negedge clk);
    chk({tag, " R4 flags after limit 2"}, 32'(lim_irq), 32'({prior[1] | h2, prior[0] | h1}));
    chk({tag, " R6 done after limit 2"}, 32'(cmp_done), 32'd1);
    chk({tag, " R8 ready back"}, 32'(smp_ready), 32'd1);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, 32'(cmp_done), 32'd0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R9 ready", 32'(smp_ready), 32'd1);
    chk("R9 done", 32'(cmp_done), 32'd0);
    chk("R9 flags", 32'(lim_irq), 32'd0);
    rd(2'd0, v); chk("R9 limit 1", 32'(v), 32'd0);
    rd(2'd1, v); chk("R9 limit 2", 32'(v), 32'd0);
  endtask

  task automatic t_fields;
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R1 limit 1 upper bits dropped", 32'(v), 32'h03FF);
    wr(2'd1, 16'hA5C3);
    rd(2'd1, v); chk("R1 limit 2 fields kept", 32'(v), 32'h01C3);
    rd(2'd0, v); chk("R1 limit 1 untouched by limit 2 write", 32'(v), 32'h03FF);
  endtask

  task automatic t_sense;
    set_lims(mk_lim(1'b1, 1'b0, 8'd10), mk_lim(1'b0, 1'b0, 8'd10));
    send("R3 +11", 1'b0, 8'd11, 2'b00, 1'b1, 1'b0);
    wr(2'd2, 16'h0003);
    send("R3 +9", 1'b0, 8'd9, 2'b00, 1'b0, 1'b1);
    wr(2'd2, 16'h0003);
    send("R3 equal +10", 1'b0, 8'd10, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_signed;
    set_lims(mk_lim(1'b1, 1'b0, 8'd5), mk_lim(1'b0, 1'b1, 8'd5));
    send("R2 -100", 1'b1, 8'd100, 2'b00, 1'b0, 1'b1);
    wr(2'd2, 16'h0003);
    send("R2 -3", 1'b1, 8'd3, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_negzero;
    set_lims(mk_lim(1'b1, 1'b1, 8'd0), mk_lim(1'b0, 1'b0, 8'd0));
    send("R2 +0 vs zeros", 1'b0, 8'd0, 2'b00, 1'b0, 1'b0);
    send("R2 -0 vs zeros", 1'b1, 8'd0, 2'b00, 1'b0, 1'b0);
    send("R2 -1 vs zeros", 1'b1, 8'd1, 2'b00, 1'b0, 1'b1);
    wr(2'd2, 16'h0003);
    send("R2 +1 vs zeros", 1'b0, 8'd1, 2'b00, 1'b1, 1'b0);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    set_lims(mk_lim(1'b1, 1'b1, 8'd100), mk_lim(1'b1, 1'b1, 8'd100));
    send("R4 both trip", 1'b0, 8'd0, 2'b00, 1'b1, 1'b1);
    set_lims(mk_lim(1'b1, 1'b0, 8'd200), mk_lim(1'b0, 1'b1, 8'd200));
    wr(2'd0, mk_lim(1'b1, 1'b0, 8'd200));
    send("R5 nothing trips", 1'b0, 8'd0, 2'b00, 1'b0, 1'b0);
    set_lims(mk_lim(1'b1, 1'b1, 8'd100), mk_lim(1'b1, 1'b1, 8'd100));
    send("R5 set again", 1'b0, 8'd0, 2'b00, 1'b1, 1'b1);
    wr(2'd0, mk_lim(1'b1, 1'b0, 8'd200));
    wr(2'd1, mk_lim(1'b0, 1'b1, 8'd200));
    send("R5 stays set", 1'b0, 8'd0, 2'b11, 1'b0, 1'b0);
    wr(2'd2, 16'h0000);
    chk("R5 zero write keeps flags", 32'(lim_irq), 32'd3);
    wr(2'd2, 16'h0001);
    chk("R5 clear bit 0 only", 32'(lim_irq), 32'd2);
    rd(2'd2, v); chk("R5 flag readback", 32'(v), 32'd2);
    wr(2'd2, 16'h0002);
    chk("R5 clear bit 1", 32'(lim_irq), 32'd0);
  endtask

  task automatic t_collide;
    set_lims(mk_lim(1'b1, 1'b1, 8'd100), mk_lim(1'b1, 1'b1, 8'd100));
    send("R5 prime", 1'b0, 8'd0, 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    smp_valid = 1'b1; smp_cmp_en = 1'b1; smp_data = 9'd0;
    @(negedge clk);
    smp_valid = 1'b0;
    cfg_wr_en = 1'b1; cfg_addr = 2'd2; cfg_wdata = 16'h0003;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R5 set wins over clear, other cleared", 32'(lim_irq), 32'd1);
    @(negedge clk);
    chk("R5 limit 2 sets after clear", 32'(lim_irq), 32'd3);
    @(negedge clk);
  endtask

  task automatic t_disabled;
    set_lims(mk_lim(1'b1, 1'b1, 8'd100), mk_lim(1'b1, 1'b1, 8'd100));
    @(negedge clk);
    smp_valid = 1'b1; smp_cmp_en = 1'b0; smp_data = 9'd0;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R7 ready stays high", 32'(smp_ready), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 no flags", 32'(lim_irq), 32'd0);
      chk("R7 no done", 32'(cmp_done), 32'd0);
    end
  endtask

  task automatic t_backpressure;
    set_lims(mk_lim(1'b1, 1'b0, 8'd50), mk_lim(1'b0, 1'b1, 8'd50));
    @(negedge clk);
    smp_valid = 1'b1; smp_cmp_en = 1'b1; smp_data = {1'b0, 8'd100};
    @(negedge clk);
    chk("R8 busy after first", 32'(smp_ready), 32'd0);
    smp_data = {1'b1, 8'd100};
    @(negedge clk);
    chk("R8 still busy", 32'(smp_ready), 32'd0);
    chk("R8 first sample flag", 32'(lim_irq), 32'd1);
    @(negedge clk);
    chk("R8 ready at done", 32'(smp_ready), 32'd1);
    chk("R8 second not taken yet", 32'(lim_irq), 32'd1);
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R8 second taken", 32'(smp_ready), 32'd0);
    @(negedge clk);
    chk("R8 second limit 1", 32'(lim_irq), 32'd1);
    @(negedge clk);
    chk("R8 second limit 2", 32'(lim_irq), 32'd3);
    chk("R8 second done", 32'(cmp_done), 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R8 taken once", 32'(smp_ready), 32'd1);
    chk("R8 no extra done", 32'(cmp_done), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_sense();
    t_signed();
    t_negzero();
    t_sticky();
    t_collide();
    t_disabled();
    t_backpressure();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule